// File: doc/BRIEF.md
# PCI Power State Access Gate

This block sits between a PCI-style target interface and a controller's register spaces. It enforces the device power state, which is either full power (D0) or powered down (D3). Software moves the block between these states by writing a two-bit power-state field with a configuration access. Each incoming access has a type: configuration, memory or I/O. The gate either forwards the access to the register spaces or completes it with a master-abort response.

In D3 only configuration traffic passes. Memory and I/O accesses are aborted and are not forwarded. The interrupt line is held low, and the port output tells the physical layer to release its wires as if no device were attached. Returning to D0 performs no internal reset. Interrupt status that is still pending and enabled raises the interrupt line as soon as the block is back in D0.

Top module: `pm_access_gate`

## Requirements
- R1: After reset the state field reads 00 (D0), `port_disable` is low, and `fwd_valid`, `cpl_valid`, `cpl_abort` and `irq_out` are all low.
- R2: A configuration access (`req_kind` 00) is forwarded in either state. The cycle after it is presented, `fwd_valid` is high with `fwd_kind` 00 and `cpl_abort` low.
- R3: In D3, a memory access (`req_kind` 01), an I/O access (10) or an access of the reserved type (11) is not forwarded. The cycle after it is presented, `cpl_abort` is high and `fwd_valid` is low. In D0 these accesses are forwarded with their type.
- R4: While the state is D3, `irq_out` stays low in the following cycle even when status and enable bits coincide.
- R5: While the state is D0, `irq_out` equals the OR of `irq_status & irq_enable`, one cycle later. A bit still pending when the block returns to D0 raises `irq_out` one cycle after the return.
- R6: A configuration write of the power-state field (`req_pm_wr` high with `req_kind` 00) with value 00 selects D0 and with value 11 selects D3. The values 01 and 10 are ignored and the state is kept.
- R7: A state change is visible on `pstate` in the cycle after the write. The writing access itself is judged by the old state.
- R8: Every accepted access produces exactly one `cpl_valid` pulse, one cycle later. `cpl_abort` is high only together with `cpl_valid`.
- R9: `port_disable` is high exactly while `pstate` is 11.
- R10: Leaving D3 needs no reset. A memory access presented in the first cycle back in D0 is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access presented this cycle |
| req_kind | input | 2 | Access type: 00 config, 01 memory, 10 I/O, 11 reserved |
| req_pm_wr | input | 1 | Access is a write of the power-state field |
| req_wdata | input | 2 | Power-state value being written |
| fwd_valid | output | 1 | Access forwarded to the register spaces |
| fwd_kind | output | 2 | Type of the forwarded access |
| cpl_valid | output | 1 | Completion strobe |
| cpl_abort | output | 1 | Master-abort flag, valid with `cpl_valid` |
| pstate | output | 2 | Current power-state field |
| port_disable | output | 1 | Release drive on the port wires |
| irq_status | input | N_IRQ | Interrupt status bits |
| irq_enable | input | N_IRQ | Interrupt enable mask |
| irq_out | output | 1 | Gated interrupt output |

## Verification
The bench targets the cycle in which the power state flips:
- It checks a memory access placed directly after a write to D3. A design that applied the new state a cycle late would forward that access instead of aborting it.
- It checks an interrupt that is pending across the D3 stay. A design that lost it would keep `irq_out` low after the return to D0.
- It writes the reserved field values 01 and 10. A design that decoded only one bit would move to D3 or D0 by mistake.

Random traffic mixes all four access types with arbitrary status and enable patterns. It also checks that an abort never appears without a completion strobe.

// File: rtl/pm_access_gate.sv
module pm_access_gate #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_pm_wr,
  input  logic [1:0]       req_wdata,
  output logic             fwd_valid,
  output logic [1:0]       fwd_kind,
  output logic             cpl_valid,
  output logic             cpl_abort,
  output logic [1:0]       pstate,
  output logic             port_disable,
  input  logic [N_IRQ-1:0] irq_status,
  input  logic [N_IRQ-1:0] irq_enable,
  output logic             irq_out
);
  localparam logic [1:0] KIND_CFG = 2'b00;
  localparam logic [1:0] PS_D0    = 2'b00;
  localparam logic [1:0] PS_D3    = 2'b11;

  logic       in_d3;
  logic       is_cfg;
  logic       blocked;
  logic       ps_write;
  logic [1:0] ps_q;

  assign in_d3    = (ps_q == PS_D3);
  assign is_cfg   = (req_kind == KIND_CFG);
  assign blocked  = in_d3 && !is_cfg;
  assign ps_write = req_valid && is_cfg && req_pm_wr &&
                    (req_wdata == PS_D0 || req_wdata == PS_D3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= PS_D0;
    else if (ps_write) ps_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_kind  <= KIND_CFG;
      cpl_valid <= 1'b0;
      cpl_abort <= 1'b0;
      irq_out   <= 1'b0;
    end else begin
      fwd_valid <= req_valid && !blocked;
      fwd_kind  <= req_valid ? req_kind : KIND_CFG;
      cpl_valid <= req_valid;
      cpl_abort <= req_valid && blocked;
      irq_out   <= !in_d3 && |(irq_status & irq_enable);
    end
  end

  assign pstate       = ps_q;
  assign port_disable = in_d3;
endmodule

// File: rtl/pm_access_gate_chk.sv
module pm_access_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       req_pm_wr,
  input logic [1:0] req_wdata,
  input logic       fwd_valid,
  input logic       cpl_valid,
  input logic       cpl_abort,
  input logic [1:0] pstate,
  input logic       port_disable,
  input logic       irq_out
);
  AST_CFG_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'b00 |=> fwd_valid && !cpl_abort); // R2
  AST_D3_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind != 2'b00 && pstate == 2'b11 |=> cpl_abort && !fwd_valid); // R3
  AST_D3_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    port_disable |=> !irq_out); // R4
  AST_BAD_CODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'b00 && req_pm_wr && (req_wdata == 2'b01 || req_wdata == 2'b10)
    |=> $stable(pstate)); // R6
  AST_CPL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> cpl_valid); // R8
  AST_NO_SPURIOUS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !cpl_valid); // R8
  AST_ABORT_WITH_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_abort |-> cpl_valid); // R8
endmodule

bind pm_access_gate pm_access_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_pm_wr(req_pm_wr), .req_wdata(req_wdata), .fwd_valid(fwd_valid),
  .cpl_valid(cpl_valid), .cpl_abort(cpl_abort), .pstate(pstate),
  .port_disable(port_disable), .irq_out(irq_out)
);

// File: tb/test_pm_access_gate.sv
`timescale 1ns/1ps
module test_pm_access_gate;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_pm_wr = 1'b0;
  logic [1:0] req_kind = 2'b00, req_wdata = 2'b00;
  logic [N-1:0] irq_status = '0, irq_enable = '0;
  logic fwd_valid, cpl_valid, cpl_abort, port_disable, irq_out;
  logic [1:0] fwd_kind, pstate;

  int checks = 0, errors = 0;
  logic [1:0] m_ps = 2'b00;

  always #2.5 clk = ~clk;

  pm_access_gate #(.N_IRQ(N)) i_pm_access_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_pm_wr(req_pm_wr), .req_wdata(req_wdata), .fwd_valid(fwd_valid),
    .fwd_kind(fwd_kind), .cpl_valid(cpl_valid), .cpl_abort(cpl_abort),
    .pstate(pstate), .port_disable(port_disable), .irq_status(irq_status),
    .irq_enable(irq_enable), .irq_out(irq_out)
  );

  function automatic logic f_abort(logic [1:0] ps, logic v, logic [1:0] k);
    return v && ps == 2'b11 && k != 2'b00;
  endfunction
  function automatic logic [1:0] f_next(logic [1:0] ps, logic v, logic [1:0] k,
                                        logic w, logic [1:0] d);
    if (v && k == 2'b00 && w && (d == 2'b00 || d == 2'b11)) return d;
    return ps;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [1:0] k, logic w, logic [1:0] d,
                      logic [N-1:0] st, logic [N-1:0] en);
    logic [1:0] old;
    req_valid = v; req_kind = k; req_pm_wr = w; req_wdata = d;
    irq_status = st; irq_enable = en;
    old = m_ps;
    @(posedge clk);
    m_ps = f_next(old, v, k, w, d);
    @(negedge clk);
    chk("R8 cpl_valid", {7'd0, cpl_valid}, {7'd0, v});
    chk("R3 cpl_abort", {7'd0, cpl_abort}, {7'd0, f_abort(old, v, k)});
    chk("R2/R3 fwd_valid", {7'd0, fwd_valid}, {7'd0, v && !f_abort(old, v, k)});
    if (v) chk("R2 fwd_kind", {6'd0, fwd_kind}, {6'd0, k});
    chk("R6/R7 pstate", {6'd0, pstate}, {6'd0, m_ps});
    chk("R9 port_disable", {7'd0, port_disable}, {7'd0, m_ps == 2'b11});
    chk("R4/R5 irq_out", {7'd0, irq_out}, {7'd0, old != 2'b11 && |(st & en)});
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pstate", {6'd0, pstate}, 8'd0);
    chk("R1 outputs", {3'd0, fwd_valid, cpl_valid, cpl_abort, irq_out, port_disable}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 interrupt in D0
    step(0, 2'b00, 0, 2'b00, 8'h10, 8'h10);
    // R7 write D3, following memory access sees D3
    step(1, 2'b00, 1, 2'b11, 8'h10, 8'h10);
    step(1, 2'b01, 0, 2'b00, 8'h10, 8'h10);
    step(1, 2'b10, 0, 2'b00, 8'hff, 8'hff);   // R3 I/O abort, R4 irq low
    step(1, 2'b00, 0, 2'b00, 8'hff, 8'hff);   // R2 config passes in D3
    step(1, 2'b00, 1, 2'b01, 8'h01, 8'h01);   // R6 ignored
    step(1, 2'b00, 1, 2'b10, 8'h01, 8'h01);   // R6 ignored
    step(1, 2'b00, 1, 2'b00, 8'h01, 8'h01);   // back to D0
    step(1, 2'b01, 0, 2'b00, 8'h01, 8'h01);   // R10 R5 forwarded, pending fires
    step(1, 2'b00, 1, 2'b10, 8'h00, 8'h00);   // R6 ignored in D0
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[2:1], r[3] && (r[5:4] == 2'b00), r[7:6],
           N'($urandom), N'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule